// File: doc/BRIEF.md
# Accumulator Register Datapath

This block is the register and operand core of a small accumulator-style processor. It keeps two 16-bit registers: an address register A, whose low 15 bits address data memory, and a data register D. Each cycle it decodes one instruction word. A word with bit 15 clear is a literal and is copied into A. A word with bit 15 set is a compute word. It picks the X operand (A, or the memory word at address A), always uses D as the Y operand, and runs a six-control-bit combinational ALU. The single result can then be stored to A, to D and to memory in any mix on the same clock edge.

Memory sits outside the block. It is read combinationally at the address the block presents. It samples the write strobe and write data on the rising clock edge. Program sequencing, branching and instruction fetch are left to the surrounding logic.

Top module: `acc_datapath`

## Requirements
- R1: While synchronous reset is high, the write strobe is low. After a rising edge with reset high, both A and D read zero.
- R2: When instruction bit 15 is 0, the whole 16-bit instruction word is written into A on the next edge. D is unchanged and the write strobe stays low.
- R3: For a compute word, the X operand is A when bit 12 is 0 and the memory read data when bit 12 is 1.
- R4: The Y operand is always the current value of D.
- R5: Bits 11..6 of a compute word control the ALU, from MSB to LSB: clear X, invert X, clear Y, invert Y, function (1 = add modulo 2^16, 0 = bitwise AND), invert result. The clear step comes before the invert step.
- R6: On a compute word, bit 5 stores the result to A, bit 4 stores it to D, and bit 3 raises the write strobe. Any combination of the three takes effect together on one edge, and all of them store the same result.
- R7: When bit 15 is 0, bits 5..3 have no effect: D keeps its value and the write strobe stays low.
- R8: The memory address is A[14:0]. The write data is the ALU result. A store to memory goes to the address A held before the edge, and the store alone does not change A.
- R9: A register whose store enable is inactive keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word for this cycle |
| mem_rdata | input | 16 | Memory word read at mem_addr |
| mem_addr | output | 15 | Memory address, low bits of A |
| mem_wdata | output | 16 | ALU result offered for a memory store |
| mem_we | output | 1 | Memory store strobe, valid for the whole cycle |
| reg_a | output | 16 | Current A register value |
| reg_d | output | 16 | Current D register value |

## Verification
A memory store and an update of A can fall in the same cycle. The store must use the address A held before the edge, and A must take the new result. This is provoked with a compute word that sets all three destination bits and uses X = A + 1. The bench then checks that the memory model holds the result at the old address, and that A and D both read that same result. A memory-sourced operand is also combined with a memory store in one word. This shows that the read data feeding X and the write strobe for the same address do not disturb each other.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

   // ALU conditioning and function controls, taken from the instruction
   typedef struct packed {
      logic clr_x;
      logic inv_x;
      logic clr_y;
      logic inv_y;
      logic fn_add;
      logic inv_out;
   } alu_ctrl_t;

   // Destination store enables, already gated by instruction kind
   typedef struct packed {
      logic to_a;
      logic to_d;
      logic to_m;
   } dest_en_t;

   localparam int unsigned ALU_CTRL_BITS = 6;
   localparam int unsigned DEST_BITS     = 3;

   function automatic alu_ctrl_t unpack_ctrl(input logic [ALU_CTRL_BITS-1:0] raw);
      alu_ctrl_t c;
      c.clr_x   = raw[5];
      c.inv_x   = raw[4];
      c.clr_y   = raw[3];
      c.inv_y   = raw[2];
      c.fn_add  = raw[1];
      c.inv_out = raw[0];
      return c;
   endfunction

endpackage

// File: rtl/acc_dp_opcond.sv
module acc_dp_opcond #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] op_in,
   input  logic             clr,
   input  logic             inv,
   output logic [WIDTH-1:0] op_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("acc_dp_opcond: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] cleared;

   always_comb begin
      cleared = clr ? '0 : op_in;
      op_out  = inv ? ~cleared : cleared;
   end

endmodule

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
   import acc_dp_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] y_in,
   input  alu_ctrl_t        ctrl,
   output logic [WIDTH-1:0] result
);

   localparam int unsigned N_OPS = 2;

   logic [WIDTH-1:0] raw_op  [N_OPS];
   logic [WIDTH-1:0] cond_op [N_OPS];
   logic             clr_sel [N_OPS];
   logic             inv_sel [N_OPS];

   always_comb begin
      raw_op[0]  = x_in;
      raw_op[1]  = y_in;
      clr_sel[0] = ctrl.clr_x;
      clr_sel[1] = ctrl.clr_y;
      inv_sel[0] = ctrl.inv_x;
      inv_sel[1] = ctrl.inv_y;
   end

   generate
      for (genvar g = 0; g < N_OPS; g++) begin : g_cond
         acc_dp_opcond #(.WIDTH(WIDTH)) cond_i (
            .op_in  (raw_op[g]),
            .clr    (clr_sel[g]),
            .inv    (inv_sel[g]),
            .op_out (cond_op[g])
         );
      end
   endgenerate

   logic [WIDTH-1:0] sum_v;
   logic [WIDTH-1:0] and_v;
   logic [WIDTH-1:0] fn_v;

   always_comb begin
      sum_v  = cond_op[0] + cond_op[1];
      and_v  = cond_op[0] & cond_op[1];
      fn_v   = ctrl.fn_add ? sum_v : and_v;
      result = ctrl.inv_out ? ~fn_v : fn_v;
   end

endmodule

// File: rtl/acc_dp_decode.sv
module acc_dp_decode
   import acc_dp_pkg::*;
#(
   parameter int unsigned WIDTH     = 16,
   parameter int unsigned KIND_POS  = 15,
   parameter int unsigned SRC_POS   = 12,
   parameter int unsigned CTRL_LSB  = 6,
   parameter int unsigned DEST_LSB  = 3
) (
   input  logic [WIDTH-1:0] instr,
   output logic             is_compute,
   output logic             x_from_mem,
   output alu_ctrl_t        ctrl,
   output dest_en_t         dest
);

   localparam int unsigned CTRL_MSB = CTRL_LSB + ALU_CTRL_BITS - 1;
   localparam int unsigned DEST_MSB = DEST_LSB + DEST_BITS - 1;

   generate
      if (KIND_POS >= WIDTH || SRC_POS >= WIDTH) begin : g_bad_pos
         $error("acc_dp_decode: kind or source bit outside the word");
      end
      if (CTRL_MSB >= SRC_POS) begin : g_bad_ctrl
         $error("acc_dp_decode: ALU control field overlaps source bit");
      end
      if (DEST_MSB >= CTRL_LSB) begin : g_bad_dest
         $error("acc_dp_decode: destination field overlaps ALU control");
      end
   endgenerate

   logic [DEST_BITS-1:0] dest_raw;

   always_comb begin
      is_compute = instr[KIND_POS];
      x_from_mem = instr[SRC_POS];
      ctrl       = unpack_ctrl(instr[CTRL_MSB:CTRL_LSB]);
      dest_raw   = instr[DEST_MSB:DEST_LSB];
      dest.to_a  = dest_raw[2] & is_compute;
      dest.to_d  = dest_raw[1] & is_compute;
      dest.to_m  = dest_raw[0] & is_compute;
   end

endmodule

// File: rtl/acc_dp_reg.sv
module acc_dp_reg #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= d;
   end

   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> (q == '0)); // R1

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      ld |=> (q == $past(d))); // R9

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(q)); // R9

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_dp_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 15,
   parameter int unsigned KIND_POS = 15,
   parameter int unsigned SRC_POS  = 12,
   parameter int unsigned CTRL_LSB = 6,
   parameter int unsigned DEST_LSB = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] instr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] reg_a,
   output logic [DATA_W-1:0] reg_d
);

   localparam int unsigned DEST_A_POS = DEST_LSB + 2;

   generate
      if (ADDR_W >= DATA_W) begin : g_bad_addr
         $error("acc_datapath: address must be narrower than A");
      end
   endgenerate

   logic              is_compute;
   logic              x_from_mem;
   alu_ctrl_t         ctrl;
   dest_en_t          dest;
   logic [DATA_W-1:0] x_op;
   logic [DATA_W-1:0] alu_res;
   logic [DATA_W-1:0] a_next;
   logic              a_ld;

   acc_dp_decode #(
      .WIDTH    (DATA_W),
      .KIND_POS (KIND_POS),
      .SRC_POS  (SRC_POS),
      .CTRL_LSB (CTRL_LSB),
      .DEST_LSB (DEST_LSB)
   ) dec_i (
      .instr      (instr),
      .is_compute (is_compute),
      .x_from_mem (x_from_mem),
      .ctrl       (ctrl),
      .dest       (dest)
   );

   // X operand source choice; Y is hard-wired to D
   always_comb x_op = x_from_mem ? mem_rdata : reg_a;

   acc_dp_alu #(.WIDTH(DATA_W)) alu_i (
      .x_in   (x_op),
      .y_in   (reg_d),
      .ctrl   (ctrl),
      .result (alu_res)
   );

   always_comb begin
      a_ld   = !is_compute || dest.to_a;
      a_next = is_compute ? alu_res : instr;
   end

   acc_dp_reg #(.WIDTH(DATA_W)) a_reg_i (
      .clk (clk),
      .rst (rst),
      .ld  (a_ld),
      .d   (a_next),
      .q   (reg_a)
   );

   acc_dp_reg #(.WIDTH(DATA_W)) d_reg_i (
      .clk (clk),
      .rst (rst),
      .ld  (dest.to_d),
      .d   (alu_res),
      .q   (reg_d)
   );

   always_comb begin
      mem_addr  = reg_a[ADDR_W-1:0];
      mem_wdata = alu_res;
      mem_we    = dest.to_m && !rst;
   end

   AST_WE_QUIET_RESET: assert property (@(posedge clk)
      rst |-> !mem_we); // R1

   AST_LITERAL_TO_A: assert property (@(posedge clk) disable iff (rst)
      !instr[KIND_POS] |=> (reg_a == $past(instr))); // R2

   AST_LITERAL_NO_STORE: assert property (@(posedge clk) disable iff (rst)
      !instr[KIND_POS] |-> !mem_we); // R7

   AST_STORE_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
      (mem_we && !instr[DEST_A_POS]) |=> $stable(reg_a)); // R8

endmodule

// File: tb/acc_datapath_tb_top.sv
module acc_datapath_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = 16'h0000;
   logic [15:0] mem_rdata;
   logic [14:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_we;
   logic [15:0] reg_a;
   logic [15:0] reg_d;

   logic [15:0] mem [32];

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   acc_datapath dut_i (
      .clk       (clk),
      .rst       (rst),
      .instr     (instr),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .reg_a     (reg_a),
      .reg_d     (reg_d)
   );

   // Memory model: combinational read, store on the rising edge
   assign mem_rdata = mem[mem_addr[4:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[4:0]] <= mem_wdata;

   function automatic logic [15:0] ref_alu(input logic [15:0] x, input logic [15:0] y,
                                           input logic [5:0] op);
      logic [15:0] xv, yv, fv;
      xv = op[5] ? 16'h0 : x;
      xv = op[4] ? ~xv : xv;
      yv = op[3] ? 16'h0 : y;
      yv = op[2] ? ~yv : yv;
      fv = op[1] ? (xv + yv) : (xv & yv);
      return op[0] ? ~fv : fv;
   endfunction

   function automatic logic [15:0] cword(input logic src, input logic [5:0] op,
                                         input logic [2:0] dst);
      return {3'b111, src, op, dst, 3'b000};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] w);
      @(negedge clk);
      instr = w;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      instr = cword(1'b0, 6'b000010, 3'b111);
      repeat (3) @(posedge clk);
      #1;
      check("R1 strobe low in reset", {15'h0, mem_we}, 16'h0);
      check("R1 A zero", reg_a, 16'h0);
      check("R1 D zero", reg_d, 16'h0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_literal();
      apply(16'h1234);
      check("R2 no strobe on literal", {15'h0, mem_we}, 16'h0);
      tick();
      check("R2 A takes literal", reg_a, 16'h1234);
      check("R2 D unchanged", reg_d, 16'h0);
      check("R8 address from A", {1'b0, mem_addr}, 16'h1234);
   endtask

   task automatic t_copy_a_to_d();
      // X AND all-ones passes X: D <= A
      apply(cword(1'b0, 6'b001100, 3'b010));
      check("R3 X is A", mem_wdata, 16'h1234);
      tick();
      check("R6 D stored", reg_d, 16'h1234);
      check("R9 A held", reg_a, 16'h1234);
   endtask

   task automatic t_alu_sweep();
      logic [5:0] ops [8];
      ops[0] = 6'b000010; ops[1] = 6'b011111; ops[2] = 6'b110111; ops[3] = 6'b010011;
      ops[4] = 6'b000000; ops[5] = 6'b010101; ops[6] = 6'b111010; ops[7] = 6'b101010;
      apply(16'h0005);
      tick();
      apply(cword(1'b0, 6'b001100, 3'b010));
      tick();
      apply(16'h0003);
      tick();
      check("R4 D loaded", reg_d, 16'h0005);
      for (int i = 0; i < 8; i++) begin
         apply(cword(1'b0, ops[i], 3'b000));
         check("R5 ALU result", mem_wdata, ref_alu(16'h0003, 16'h0005, ops[i]));
         check("R9 no store strobe", {15'h0, mem_we}, 16'h0);
      end
      tick();
      check("R9 A held with no destination", reg_a, 16'h0003);
      check("R9 D held with no destination", reg_d, 16'h0005);
   endtask

   task automatic t_mem_operand();
      // A = 3, D = 5, mem[3] = 0x0040: store M + D back to mem[3]
      apply(cword(1'b1, 6'b000010, 3'b001));
      check("R3 X is memory data", mem_wdata, 16'h0045);
      check("R6 strobe raised", {15'h0, mem_we}, 16'h1);
      tick();
      check("R8 memory stored at A", mem[3], 16'h0045);
      check("R8 A not changed by store", reg_a, 16'h0003);
      check("R4 D kept", reg_d, 16'h0005);
   endtask

   task automatic t_all_dest();
      // X + 1 with X = A (3) to A, D and memory together
      apply(cword(1'b0, 6'b011111, 3'b111));
      check("R6 result X+1", mem_wdata, ref_alu(16'h0003, 16'h0005, 6'b011111));
      tick();
      check("R6 A got result", reg_a, 16'h0004);
      check("R6 D got result", reg_d, 16'h0004);
      check("R8 store used old A address", mem[3], 16'h0004);
      check("R8 next address untouched", mem[4], 16'h0000);
   endtask

   task automatic t_literal_with_dest_bits();
      apply(16'h0038);
      check("R7 no strobe", {15'h0, mem_we}, 16'h0);
      tick();
      check("R7 D unchanged", reg_d, 16'h0004);
      check("R2 A takes word", reg_a, 16'h0038);
   endtask

   task automatic t_reset_mid();
      apply(cword(1'b0, 6'b000010, 3'b111));
      rst = 1'b1;
      #1;
      check("R1 strobe low under reset", {15'h0, mem_we}, 16'h0);
      tick();
      check("R1 A cleared", reg_a, 16'h0);
      check("R1 D cleared", reg_d, 16'h0);
      check("R1 memory not stored", mem[24], 16'h0000);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = 16'h0000;
      mem[3] = 16'h0040;
      t_reset();
      t_literal();
      t_copy_a_to_d();
      t_alu_sweep();
      t_mem_operand();
      t_all_dest();
      t_literal_with_dest_bits();
      t_reset_mid();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule